// File: doc/BRIEF.md
# Frame-Based DMA Audio Sequencer

The sequencer plays 8-bit audio held in memory. Each frame is a block of 16-bit words that runs from a start address up to an end address. The end address points one word past the last sample. Software programs the frame bounds, a mode and a control word through a byte-wide register port. It then sets the enable bit. From there the block fetches words through a request/grant read port and keeps up to two words queued ahead. At a programmable sample rate it presents a left and a right sample together with a one-cycle strobe.

In stereo each fetched word carries one sample pair. In mono each byte of a word is played in turn on both channels. Stored samples use sign-magnitude coding, and the block converts them to two's complement at its outputs. A one-cycle end-of-frame pulse can serve as an interrupt.

In repeat mode the start and end registers are read again every time a frame ends. Software can therefore queue the next frame while the current one plays, and the switch has no gap. In single mode the block stops by itself once the last sample has had its full sample period.

Top module: `frame_audio_seq`

## Requirements
- R1: After reset, every register reads 0, the selected mode is stereo at the slowest rate, both sample outputs are 0, and no memory request or strobe is raised.
- R2: The register offsets are fixed:
  - 0 is control: bit 0 enable, bit 1 repeat.
  - 1 is mode: bits 1:0 rate, bit 7 mono.
  - 2, 3 and 4 hold the start address high, mid and low bytes.
  - 5, 6 and 7 hold the current address counter high, mid and low bytes. These are read-only, and writes to them change nothing.
  - 8, 9 and 10 hold the end address high, mid and low bytes.
  - Start, end, control and mode read back the value written.
- R3: Setting enable while it is clear loads the address counter from the start register with bit 0 forced to 0. Each granted fetch advances the counter by 2. The memory request holds an even address that stays stable until it is granted.
- R4: In stereo, each fetched word gives one sample: the upper byte goes to the left output and the lower byte to the right output.
- R5: In mono, each fetched word gives two samples, the upper byte first and then the lower byte, and each is driven on both outputs.
- R6: A stored byte s with magnitude m = s[6:0] is output as +m when s[7] is 0 and as -m in 8-bit two's complement when s[7] is 1. A byte of 0x80 gives 0.
- R7: Mode rate codes 0, 1, 2 and 3 give a sample period of BASE_DIV*8, *4, *2 and *1 clock cycles. The sample strobe lasts one cycle and comes once per period whenever a word is queued.
- R8: The end-of-frame output pulses for one cycle after the fetch that brings the counter up to the latched end address.
- R9: In repeat mode, the counter reloads from the start register at each frame end, and the end register is latched again. Start and end values written during a frame only take effect from the next frame.
- R10: In single mode, fetching stops at the frame end. One sample period after the last sample, enable clears by itself, both outputs return to 0, and no further strobes or requests follow.
- R11: When software clears enable, the memory request drops at once, and both outputs are 0 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on reg_addr_i) |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | 24 | Byte address of the requested word |
| mem_gnt_i | input | 1 | Grant; mem_rdata_i is valid in the same cycle |
| mem_rdata_i | input | 16 | Fetched word |
| left_o | output | 8 | Left sample, two's complement |
| right_o | output | 8 | Right sample, two's complement |
| sample_stb_o | output | 1 | One-cycle strobe for a new sample pair |
| frame_end_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check, on every cycle:
- a memory request only while enabled, always at an even address, held unchanged until granted;
- outputs at zero after any disabled cycle;
- strobes only from an enabled block;
- equal channels in mono;
- no output ever equal to 0x80.

Only the scenarios can show the rest:
- the sample order in stereo and mono, and the sign-magnitude conversion against a memory model;
- the spacing between strobes at each rate;
- the counter ending on the end address;
- the single-frame self-stop;
- a queued frame taking over exactly at a frame boundary in repeat mode, including while grants are stalled.

// File: rtl/fas_pkg.sv
package fas_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] REG_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] REG_MODE   = 4'd1;
  localparam logic [REG_AW-1:0] REG_BASE_H = 4'd2;
  localparam logic [REG_AW-1:0] REG_BASE_M = 4'd3;
  localparam logic [REG_AW-1:0] REG_BASE_L = 4'd4;
  localparam logic [REG_AW-1:0] REG_CNT_H  = 4'd5;
  localparam logic [REG_AW-1:0] REG_CNT_M  = 4'd6;
  localparam logic [REG_AW-1:0] REG_CNT_L  = 4'd7;
  localparam logic [REG_AW-1:0] REG_END_H  = 4'd8;
  localparam logic [REG_AW-1:0] REG_END_M  = 4'd9;
  localparam logic [REG_AW-1:0] REG_END_L  = 4'd10;

  // sign-magnitude byte to two's complement
  function automatic logic [BYTE_W-1:0] sm_to_tc(input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] mag;
    mag = {1'b0, s[BYTE_W-2:0]};
    return s[BYTE_W-1] ? (~mag + 1'b1) : mag;
  endfunction
endpackage

// File: rtl/fas_regs.sv
module fas_regs
  import fas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] cnt_i,
  input  logic              stop_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              en_o,
  output logic              rep_o,
  output logic              mono_o,
  output logic [1:0]        rate_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] end_o,
  output logic              start_o
);
  logic              en_q, rep_q, mono_q;
  logic [1:0]        rate_q;
  logic [ADDR_W-1:0] base_q, end_q;

  assign start_o = wr_i && (addr_i == REG_CTRL) && wdata_i[0] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      rep_q  <= 1'b0;
      mono_q <= 1'b0;
      rate_q <= 2'd0;
      base_q <= '0;
      end_q  <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          REG_CTRL:   begin en_q <= wdata_i[0]; rep_q <= wdata_i[1]; end
          REG_MODE:   begin rate_q <= wdata_i[1:0]; mono_q <= wdata_i[7]; end
          REG_BASE_H: base_q[23:16] <= wdata_i;
          REG_BASE_M: base_q[15:8]  <= wdata_i;
          REG_BASE_L: base_q[7:0]   <= wdata_i;
          REG_END_H:  end_q[23:16]  <= wdata_i;
          REG_END_M:  end_q[15:8]   <= wdata_i;
          REG_END_L:  end_q[7:0]    <= wdata_i;
          default: ;
        endcase
      end
      if (stop_i && !(wr_i && addr_i == REG_CTRL)) en_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL:   rdata_o = {6'd0, rep_q, en_q};
      REG_MODE:   rdata_o = {mono_q, 5'd0, rate_q};
      REG_BASE_H: rdata_o = base_q[23:16];
      REG_BASE_M: rdata_o = base_q[15:8];
      REG_BASE_L: rdata_o = base_q[7:0];
      REG_CNT_H:  rdata_o = cnt_i[23:16];
      REG_CNT_M:  rdata_o = cnt_i[15:8];
      REG_CNT_L:  rdata_o = cnt_i[7:0];
      REG_END_H:  rdata_o = end_q[23:16];
      REG_END_M:  rdata_o = end_q[15:8];
      REG_END_L:  rdata_o = end_q[7:0];
      default:    rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign rep_o  = rep_q;
  assign mono_o = mono_q;
  assign rate_o = rate_q;
  assign base_o = {base_q[ADDR_W-1:1], 1'b0};
  assign end_o  = end_q;
endmodule

// File: rtl/fas_fetch.sv
module fas_fetch
  import fas_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              rep_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              pop_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] head_o,
  output logic              head_vld_o,
  output logic              done_o,
  output logic              eop_o,
  output logic [ADDR_W-1:0] cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] buf_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  fill_q;
  logic [ADDR_W-1:0] addr_q, end_q, addr_nx;
  logic              done_q, eop_q, push, hit;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign mem_req_o  = en_i && !done_q && (fill_q < CNT_W'(DEPTH));
  assign mem_addr_o = addr_q;
  assign push       = mem_req_o && mem_gnt_i;
  assign addr_nx    = addr_q + ADDR_W'(2);
  assign hit        = (addr_nx == end_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      end_q  <= '0;
      done_q <= 1'b0;
      eop_q  <= 1'b0;
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      eop_q <= 1'b0;
      if (start_i) begin
        addr_q <= base_i;
        end_q  <= end_i;
        done_q <= 1'b0;
        wp_q   <= '0;
        rp_q   <= '0;
        fill_q <= '0;
      end else if (!en_i) begin
        done_q <= 1'b0;
        wp_q   <= '0;
        rp_q   <= '0;
        fill_q <= '0;
      end else begin
        if (push) begin
          wp_q <= ptr_inc(wp_q);
          if (hit) begin
            eop_q <= 1'b1;
            if (rep_i) begin
              addr_q <= base_i;
              end_q  <= end_i;
            end else begin
              addr_q <= addr_nx;
              done_q <= 1'b1;
            end
          end else begin
            addr_q <= addr_nx;
          end
        end
        if (pop_i) rp_q <= ptr_inc(rp_q);
        case ({push, pop_i})
          2'b10:   fill_q <= fill_q + 1'b1;
          2'b01:   fill_q <= fill_q - 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) buf_q[wp_q] <= mem_rdata_i;
  end

  assign head_o     = buf_q[rp_q];
  assign head_vld_o = (fill_q != '0);
  assign done_o     = done_q;
  assign eop_o      = eop_q;
  assign cnt_o      = addr_q;
endmodule

// File: rtl/fas_player.sv
module fas_player
  import fas_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mono_i,
  input  logic [1:0]        rate_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              head_vld_i,
  input  logic              done_i,
  output logic              pop_o,
  output logic              stop_o,
  output logic [BYTE_W-1:0] left_o,
  output logic [BYTE_W-1:0] right_o,
  output logic              stb_o
);
  localparam int MAX_DIV = BASE_DIV * 8;
  localparam int DIV_W   = $clog2(MAX_DIV);

  logic [DIV_W-1:0]  div_q;
  logic [DIV_W:0]    period;
  logic              tick, sel_q, stb_q;
  logic [BYTE_W-1:0] l_q, r_q, mono_byte;

  assign period    = (DIV_W + 1)'(BASE_DIV) << (2'd3 - rate_i);
  assign tick      = en_i && ({1'b0, div_q} >= period - 1'b1);
  assign mono_byte = sel_q ? head_i[7:0] : head_i[15:8];
  assign pop_o     = tick && head_vld_i && (!mono_i || sel_q);
  assign stop_o    = tick && !head_vld_i && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sel_q <= 1'b0;
      stb_q <= 1'b0;
      l_q   <= '0;
      r_q   <= '0;
    end else begin
      stb_q <= 1'b0;
      if (!en_i) begin
        div_q <= '0;
        sel_q <= 1'b0;
        l_q   <= '0;
        r_q   <= '0;
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (head_vld_i) begin
            stb_q <= 1'b1;
            if (mono_i) begin
              l_q   <= sm_to_tc(mono_byte);
              r_q   <= sm_to_tc(mono_byte);
              sel_q <= ~sel_q;
            end else begin
              l_q <= sm_to_tc(head_i[15:8]);
              r_q <= sm_to_tc(head_i[7:0]);
            end
          end else if (done_i) begin
            l_q <= '0;
            r_q <= '0;
          end
        end
      end
    end
  end

  assign left_o  = l_q;
  assign right_o = r_q;
  assign stb_o   = stb_q;
endmodule

// File: rtl/frame_audio_seq.sv
module frame_audio_seq
  import fas_pkg::*;
#(
  parameter int BASE_DIV   = 4,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] left_o,
  output logic [BYTE_W-1:0] right_o,
  output logic              sample_stb_o,
  output logic              frame_end_o
);
  logic              ctrl_en, ctrl_rep, mode_mono, start, stop, pop, done, head_vld;
  logic [1:0]        mode_rate;
  logic [ADDR_W-1:0] base, end_addr, cnt;
  logic [WORD_W-1:0] head;

  fas_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (cnt),
    .stop_i  (stop),
    .rdata_o (reg_rdata_o),
    .en_o    (ctrl_en),
    .rep_o   (ctrl_rep),
    .mono_o  (mode_mono),
    .rate_o  (mode_rate),
    .base_o  (base),
    .end_o   (end_addr),
    .start_o (start)
  );

  fas_fetch #(.DEPTH(FIFO_DEPTH)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_en),
    .start_i     (start),
    .rep_i       (ctrl_rep),
    .base_i      (base),
    .end_i       (end_addr),
    .pop_i       (pop),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rdata_i (mem_rdata_i),
    .head_o      (head),
    .head_vld_o  (head_vld),
    .done_o      (done),
    .eop_o       (frame_end_o),
    .cnt_o       (cnt)
  );

  fas_player #(.BASE_DIV(BASE_DIV)) u_player (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_en),
    .mono_i     (mode_mono),
    .rate_i     (mode_rate),
    .head_i     (head),
    .head_vld_i (head_vld),
    .done_i     (done),
    .pop_o      (pop),
    .stop_o     (stop),
    .left_o     (left_o),
    .right_o    (right_o),
    .stb_o      (sample_stb_o)
  );
endmodule

// File: rtl/fas_checker.sv
module fas_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        mono_i,
  input logic        mem_req_i,
  input logic        mem_gnt_i,
  input logic [23:0] mem_addr_i,
  input logic [7:0]  left_i,
  input logic [7:0]  right_i,
  input logic        stb_i
);
  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> en_i); // R11
  AST_REQ_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> !mem_addr_i[0]); // R3
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_gnt_i && en_i) |=> (!mem_req_i || $stable(mem_addr_i))); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (left_i == 8'd0 && right_i == 8'd0)); // R10
  AST_STB_FROM_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> $past(en_i)); // R7
  AST_MONO_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && $past(mono_i)) |-> (left_i == right_i)); // R5
  AST_NO_NEG_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_i != 8'h80 && right_i != 8'h80)); // R6
endmodule

bind frame_audio_seq fas_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (ctrl_en),
  .mono_i     (mode_mono),
  .mem_req_i  (mem_req_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_addr_i (mem_addr_o),
  .left_i     (left_o),
  .right_i    (right_o),
  .stb_i      (sample_stb_o)
);

// File: tb/frame_audio_seq_tb.sv
module frame_audio_seq_tb;
  localparam int BD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_gnt, stb, eop;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [7:0]  left, right;
  logic        stall_on = 1'b0;

  logic [15:0] mem [256];
  int n_chk = 0, n_fail = 0, cyc = 0, cap_n = 0, eop_n = 0;
  logic [7:0] cap_l [64];
  logic [7:0] cap_r [64];
  int         cap_t [64];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_gnt   = mem_req & ~(stall_on & cyc[0]);
  assign mem_rdata = mem[mem_addr[8:1]];

  frame_audio_seq #(.BASE_DIV(BD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .left_o(left), .right_o(right), .sample_stb_o(stb), .frame_end_o(eop)
  );

  always @(negedge clk) begin
    if (stb) begin
      if (cap_n < 64) begin
        cap_l[cap_n] <= left;
        cap_r[cap_n] <= right;
        cap_t[cap_n] <= cyc;
      end
      cap_n <= cap_n + 1;
    end
    if (eop) eop_n <= eop_n + 1;
  end

  function automatic logic [7:0] exp_tc(input logic [7:0] s);
    logic [7:0] m;
    m = {1'b0, s[6:0]};
    if (s[7]) return 8'(0 - m);
    return m;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    #2 d = reg_rdata;
  endtask

  task automatic set_frame(input logic [23:0] b, input logic [23:0] e);
    wr(4'd2, b[23:16]); wr(4'd3, b[15:8]); wr(4'd4, b[7:0]);
    wr(4'd8, e[23:16]); wr(4'd9, e[15:8]); wr(4'd10, e[7:0]);
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(4'd0, d);
      if (!d[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), d);
      chk("R1", $sformatf("reg %0d after reset", a), d, 0);
    end
    chk("R1", "left after reset", left, 0);
    chk("R1", "right after reset", right, 0);
    chk("R1", "mem_req after reset", mem_req, 0);
    chk("R1", "strobe after reset", stb, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    set_frame(24'h123457, 24'h000130);
    rd(4'd2, d); chk("R2", "start high", d, 8'h12);
    rd(4'd4, d); chk("R2", "start low", d, 8'h57);
    rd(4'd9, d); chk("R2", "end mid", d, 8'h01);
    rd(4'd10, d); chk("R2", "end low", d, 8'h30);
    wr(4'd1, 8'h83);
    rd(4'd1, d); chk("R2", "mode readback", d, 8'h83);
    wr(4'd5, 8'hFF); wr(4'd7, 8'hFF);
    rd(4'd5, d); chk("R2", "counter high ignores write", d, 0);
    rd(4'd7, d); chk("R2", "counter low ignores write", d, 0);
    wr(4'd1, 8'h00);
  endtask

  // single-frame stereo play at a given rate
  task automatic t_stereo(input logic [23:0] b, input int words, input logic [1:0] rate);
    int s0, e0, per, w0;
    logic [7:0] d;
    logic [23:0] cnt;
    logic [15:0] w;
    per = BD << (3 - rate);
    w0  = b[8:1];
    set_frame(b, {b[23:1], 1'b0} + 24'(2 * words));
    wr(4'd1, {6'd0, rate});
    s0 = cap_n; e0 = eop_n;
    wr(4'd0, 8'h01);
    wait_idle();
    chk("R10", "stereo sample count", cap_n - s0, words);
    chk("R8", "single frame end pulses", eop_n - e0, 1);
    for (int k = 0; k < words; k++) begin
      w = mem[w0 + k];
      chk("R4", $sformatf("left %0d", k), cap_l[s0 + k], exp_tc(w[15:8]));
      chk("R4", $sformatf("right %0d", k), cap_r[s0 + k], exp_tc(w[7:0]));
      if (k > 0) chk("R7", $sformatf("period %0d", k), cap_t[s0 + k] - cap_t[s0 + k - 1], per);
    end
    rd(4'd5, d); cnt[23:16] = d;
    rd(4'd6, d); cnt[15:8] = d;
    rd(4'd7, d); cnt[7:0] = d;
    chk("R3", "counter at end", cnt, {b[23:1], 1'b0} + 24'(2 * words));
    chk("R10", "left zero after stop", left, 0);
    chk("R10", "right zero after stop", right, 0);
    repeat (40) @(negedge clk);
    chk("R10", "no samples after stop", cap_n - s0, words);
    chk("R10", "no request after stop", mem_req, 0);
  endtask

  task automatic t_mono();
    int s0, e0;
    logic [15:0] w;
    logic [7:0] b;
    set_frame(24'h000060, 24'h000066);
    wr(4'd1, 8'h82);
    s0 = cap_n; e0 = eop_n;
    wr(4'd0, 8'h01);
    wait_idle();
    chk("R5", "mono sample count", cap_n - s0, 6);
    chk("R8", "mono frame end pulses", eop_n - e0, 1);
    for (int k = 0; k < 6; k++) begin
      w = mem[8'h30 + k / 2];
      b = (k % 2 == 0) ? w[15:8] : w[7:0];
      chk("R5", $sformatf("mono left %0d", k), cap_l[s0 + k], exp_tc(b));
      chk("R5", $sformatf("mono right %0d", k), cap_r[s0 + k], exp_tc(b));
    end
    wr(4'd1, 8'h00);
  endtask

  task automatic t_chain();
    int s0, e0, wi;
    logic [15:0] w;
    logic [7:0] d;
    stall_on = 1'b1;
    set_frame(24'h000100, 24'h000106);
    wr(4'd1, 8'h00);
    s0 = cap_n; e0 = eop_n;
    wr(4'd0, 8'h03);
    set_frame(24'h000180, 24'h000184);
    for (int i = 0; i < 2000 && cap_n - s0 < 9; i++) @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      wi = (k < 3) ? 8'h80 + k : 8'hC0 + (k - 3) % 2;
      w = mem[wi];
      chk("R9", $sformatf("chain left %0d", k), cap_l[s0 + k], exp_tc(w[15:8]));
      chk("R9", $sformatf("chain right %0d", k), cap_r[s0 + k], exp_tc(w[7:0]));
    end
    chk("R8", "repeat frame end pulses at least 3", int'(eop_n - e0 >= 3), 1);
    wr(4'd0, 8'h00);
    chk("R11", "request dropped on disable", mem_req, 0);
    @(negedge clk);
    chk("R11", "left zero on disable", left, 0);
    chk("R11", "right zero on disable", right, 0);
    rd(4'd0, d);
    chk("R11", "enable clear", d[0], 0);
    stall_on = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i * 37 + 5), 8'(i * 91 + 200)};
    mem[8'h11] = 16'h8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_stereo(24'h000040, 4, 2'd3);
    t_stereo(24'h000021, 2, 2'd1);
    t_mono();
    t_chain();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule